// File: doc/BRIEF.md
# Tournament Parent Selector

This block picks the two parents for one mating step of a hardware genetic algorithm. When started, it runs a binary tournament. It draws two random population indices from an internal 16-bit linear feedback shift register (LFSR). It fetches the fitness of both candidates from an external fitness memory and keeps the fitter one. It then runs a second tournament of the same kind for the other parent. Fitness here is an accumulated pattern error, so the smaller value is the fitter individual.

The fitness memory sits outside the block and answers a read one clock after the request. The block issues the two reads back to back and compares the values as they come back. A random draw that lands outside the population is thrown away and the next generator value is used. If the second tournament returns the same individual as the first, the second tournament is run again with fresh draws, so the two parents always differ. A one-cycle done pulse marks the pair as valid.

Top module: `tourney_select`

## Requirements
- R1: After reset, done, busy and fit_rd are 0, and both parent outputs are 0.
- R2: The generator resets to 0xACE1. When seed_load is high while the block is idle, the generator takes seed_value on the next edge, and a zero seed is replaced by 0x0001. Each update shifts the state left by one bit and inserts, at bit 0, the XOR of bits 15, 13, 12 and 10. The state never becomes zero.
- R3: Each draw cycle uses the low IDX_W bits of the current generator state as a candidate, where IDX_W = clog2(POP), and then advances the generator once. A candidate that is not below POP is discarded, and the next cycle draws again.
- R4: In a tournament, the first accepted candidate is compared with the second accepted candidate, and the one with the smaller fitness value becomes the winner.
- R5: When the two candidates of a tournament have equal fitness, the one with the lower index wins. This includes a candidate drawn twice.
- R6: The first tournament gives parent_a. If the second tournament's winner equals parent_a, the second tournament is repeated with new draws until it differs, and that winner becomes parent_b.
- R7: A fitness read is a cycle with fit_rd high and an index on fit_addr. fit_data is taken one cycle after the read. fit_addr is always below POP while fit_rd is high.
- R8: busy is high from the edge that accepts start until the pair is complete. done is then high for exactly one cycle, while busy is already low. parent_a and parent_b hold their values until the next start is accepted.
- R9: start and seed_load are ignored while busy is high. A pair completes only after a start that was accepted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load seed_value into the generator (idle only) |
| seed_value | input | 16 | Generator seed |
| start | input | 1 | Begin selection of one parent pair |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle pulse: parent pair valid |
| fit_rd | output | 1 | Fitness memory read request |
| fit_addr | output | IDX_W | Fitness memory read index |
| fit_data | input | FIT_W | Fitness value, one cycle after the request |
| parent_a | output | IDX_W | Winner of the first tournament |
| parent_b | output | IDX_W | Winner of the second tournament, differs from parent_a |

## Verification
The assertions assume that the fitness memory returns, one cycle after each request, the value stored at the requested index. They also assume that the memory does not change while a pair is being selected. The population must hold at least two individuals, otherwise two distinct parents cannot exist. The bench plays the memory itself with exactly that one-cycle registered read. It rewrites the fitness contents only while the block is idle, and it uses a 12-entry population, so the rejection path and the redraw of equal parents both occur.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;

    localparam int          LFSR_W     = 16;
    localparam logic [15:0] LFSR_RESET = 16'hACE1;
    localparam logic [15:0] LFSR_SAFE  = 16'h0001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DRAW_X,
        PH_DRAW_Y,
        PH_READ_X,
        PH_READ_Y,
        PH_JUDGE
    } phase_e;

    // one Fibonacci step of x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // an all-zero state would lock the register
    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_SAFE : s;
    endfunction

endpackage

// File: rtl/tsel_lfsr.sv
`timescale 1ns/1ps
module tsel_lfsr
    import tsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)       state <= LFSR_RESET;
        else if (load) state <= seed_fix(seed);
        else if (step) state <= lfsr_step(state);
    end

    // R2: generator never sits in the locked all-zero state
    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst) state != '0);

    // R2: generator holds unless loaded or stepped
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(state));

endmodule

// File: rtl/tsel_judge.sv
`timescale 1ns/1ps
module tsel_judge #(
    parameter int IDX_W = 4,
    parameter int FIT_W = 8
) (
    input  logic [IDX_W-1:0] idx_x,
    input  logic [FIT_W-1:0] fit_x,
    input  logic [IDX_W-1:0] idx_y,
    input  logic [FIT_W-1:0] fit_y,
    output logic [IDX_W-1:0] winner
);

    logic y_better;
    logic tie;

    always_comb begin
        y_better = fit_y < fit_x;
        tie      = fit_y == fit_x;
        if (y_better)                 winner = idx_y;
        else if (tie && idx_y < idx_x) winner = idx_y;
        else                           winner = idx_x;
    end

endmodule

// File: rtl/tsel_ctrl.sv
`timescale 1ns/1ps
module tsel_ctrl
    import tsel_pkg::*;
#(
    parameter int POP   = 12,
    parameter int IDX_W = 4,
    parameter int FIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LFSR_W-1:0] rnd,
    input  logic [FIT_W-1:0]  fit_data,
    input  logic [IDX_W-1:0]  winner,
    output logic              step,
    output logic              fit_rd,
    output logic [IDX_W-1:0]  fit_addr,
    output logic [IDX_W-1:0]  cand_x,
    output logic [IDX_W-1:0]  cand_y,
    output logic [FIT_W-1:0]  fit_x,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  parent_a,
    output logic [IDX_W-1:0]  parent_b
);

    localparam logic [IDX_W:0] POP_EXT = (IDX_W+1)'(POP);

    phase_e           phase;
    logic             second;
    logic [IDX_W-1:0] draw_idx;
    logic             draw_ok;

    always_comb begin
        draw_idx = rnd[IDX_W-1:0];
        draw_ok  = {1'b0, draw_idx} < POP_EXT;
        step     = (phase == PH_DRAW_X) || (phase == PH_DRAW_Y);
        fit_rd   = (phase == PH_READ_X) || (phase == PH_READ_Y);
        fit_addr = (phase == PH_READ_Y) ? cand_y : cand_x;
        busy     = phase != PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            second   <= 1'b0;
            cand_x   <= '0;
            cand_y   <= '0;
            fit_x    <= '0;
            parent_a <= '0;
            parent_b <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        second <= 1'b0;
                        phase  <= PH_DRAW_X;
                    end
                end
                PH_DRAW_X: begin
                    if (draw_ok) begin
                        cand_x <= draw_idx;
                        phase  <= PH_DRAW_Y;
                    end
                end
                PH_DRAW_Y: begin
                    if (draw_ok) begin
                        cand_y <= draw_idx;
                        phase  <= PH_READ_X;
                    end
                end
                PH_READ_X: phase <= PH_READ_Y;
                PH_READ_Y: begin
                    fit_x <= fit_data;   // answer to the PH_READ_X request
                    phase <= PH_JUDGE;
                end
                PH_JUDGE: begin
                    if (!second) begin
                        parent_a <= winner;
                        second   <= 1'b1;
                        phase    <= PH_DRAW_X;
                    end else if (winner == parent_a) begin
                        phase <= PH_DRAW_X;
                    end else begin
                        parent_b <= winner;
                        done     <= 1'b1;
                        phase    <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: completion marker lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done never overlaps an active selection
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: parents frozen while idle and no start is taken
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(parent_a) && $stable(parent_b)));

    // R6: delivered parents differ
    a_r6_distinct: assert property (@(posedge clk) disable iff (rst)
        done |-> (parent_a != parent_b));

    // R7: reads stay inside the population
    a_r7_addr_range: assert property (@(posedge clk) disable iff (rst)
        fit_rd |-> ({1'b0, fit_addr} < POP_EXT));

    // R3: accepted candidates are inside the population
    a_r3_cand_range: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_JUDGE) |-> ({1'b0, cand_x} < POP_EXT && {1'b0, cand_y} < POP_EXT));

    // R4: judged winner is never less fit than the other candidate
    a_r4_fitter: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_JUDGE) |->
            ((winner == cand_x) ? (fit_x <= fit_data) : (fit_data <= fit_x)));

    // R9: generator does not advance while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !step);

endmodule

// File: rtl/tourney_select.sv
`timescale 1ns/1ps
module tourney_select
    import tsel_pkg::*;
#(
    parameter int POP   = 12,
    parameter int FIT_W = 8,
    localparam int IDX_W = (POP > 1) ? $clog2(POP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic [15:0]      seed_value,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             fit_rd,
    output logic [IDX_W-1:0] fit_addr,
    input  logic [FIT_W-1:0] fit_data,
    output logic [IDX_W-1:0] parent_a,
    output logic [IDX_W-1:0] parent_b
);

    logic [LFSR_W-1:0] rnd;
    logic              step;
    logic              load_ok;
    logic [IDX_W-1:0]  cand_x;
    logic [IDX_W-1:0]  cand_y;
    logic [FIT_W-1:0]  fit_x;
    logic [IDX_W-1:0]  winner;

    assign load_ok = seed_load && !busy;

    tsel_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (load_ok),
        .seed  (seed_value),
        .step  (step),
        .state (rnd)
    );

    tsel_judge #(.IDX_W(IDX_W), .FIT_W(FIT_W)) u_judge (
        .idx_x  (cand_x),
        .fit_x  (fit_x),
        .idx_y  (cand_y),
        .fit_y  (fit_data),
        .winner (winner)
    );

    tsel_ctrl #(.POP(POP), .IDX_W(IDX_W), .FIT_W(FIT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rnd      (rnd),
        .fit_data (fit_data),
        .winner   (winner),
        .step     (step),
        .fit_rd   (fit_rd),
        .fit_addr (fit_addr),
        .cand_x   (cand_x),
        .cand_y   (cand_y),
        .fit_x    (fit_x),
        .busy     (busy),
        .done     (done),
        .parent_a (parent_a),
        .parent_b (parent_b)
    );

    initial begin
        a_r6_pop_min: assert (POP >= 2);
    end

endmodule

// File: tb/tourney_select_test.sv
`timescale 1ns/1ps
module tourney_select_test;

    localparam int POP   = 12;
    localparam int FIT_W = 8;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             seed_load = 1'b0;
    logic [15:0]      seed_value = '0;
    logic             start = 1'b0;
    logic             busy, done, fit_rd;
    logic [IDX_W-1:0] fit_addr, parent_a, parent_b;
    logic [FIT_W-1:0] fit_data = '0;

    logic [FIT_W-1:0] fit_mem [POP];
    logic [15:0]      lfsr_m;
    int               checks = 0;
    int               failures = 0;
    int               range_bad = 0;
    bit               finished = 0;

    // {seed, fitness pattern}: 0 ascending, 1 descending, 2 flat, 3 banded ties
    localparam logic [17:0] VEC [8] = '{
        {16'h1D2B, 2'd0}, {16'h5A5A, 2'd1}, {16'h000F, 2'd2}, {16'hBEEF, 2'd3},
        {16'h0123, 2'd1}, {16'hFFFF, 2'd0}, {16'h8001, 2'd3}, {16'h7E3C, 2'd2}
    };

    tourney_select #(.POP(POP), .FIT_W(FIT_W)) uut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
        .start(start), .busy(busy), .done(done), .fit_rd(fit_rd),
        .fit_addr(fit_addr), .fit_data(fit_data),
        .parent_a(parent_a), .parent_b(parent_b)
    );

    always #10 clk = ~clk;

    // fitness memory with one cycle of read latency (R7)
    always @(posedge clk) begin
        if (fit_rd) begin
            if (fit_addr < POP) fit_data <= fit_mem[fit_addr];
            else                range_bad <= range_bad + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic m_draw(output logic [IDX_W-1:0] v);
        logic [IDX_W-1:0] c;
        do begin
            c = lfsr_m[IDX_W-1:0];
            lfsr_m = m_next(lfsr_m);
        end while (c >= POP);
        v = c;
    endtask

    task automatic m_tourney(output logic [IDX_W-1:0] w);
        logic [IDX_W-1:0] x, y;
        m_draw(x);
        m_draw(y);
        if (fit_mem[y] < fit_mem[x])       w = y;
        else if (fit_mem[x] < fit_mem[y])  w = x;
        else                               w = (x < y) ? x : y;
    endtask

    task automatic m_pair(output logic [IDX_W-1:0] a, output logic [IDX_W-1:0] b);
        m_tourney(a);
        do m_tourney(b); while (b == a);
    endtask

    task automatic fill(input logic [1:0] mode);
        for (int i = 0; i < POP; i++) begin
            case (mode)
                2'd0:    fit_mem[i] = FIT_W'(i * 10);
                2'd1:    fit_mem[i] = FIT_W'(200 - i * 10);
                2'd2:    fit_mem[i] = 8'd7;
                default: fit_mem[i] = FIT_W'(i % 3);
            endcase
        end
    endtask

    task automatic load_seed(input logic [15:0] s);
        @(negedge clk);
        seed_load = 1'b1;
        seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        lfsr_m = (s == 16'h0) ? 16'h0001 : s;
    endtask

    // start a pair; optionally poke start/seed_load while busy
    task automatic run_pair(input string req, input bit poke);
        logic [IDX_W-1:0] ea, eb;
        int wait_n;
        m_pair(ea, eb);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R8 busy after start"}, busy, 1);
        if (poke) begin
            seed_load = 1'b1;
            seed_value = 16'h1234;
            start = 1'b1;
            @(negedge clk);
            seed_load = 1'b0;
            start = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        chk({req, " R8 done seen"}, done, 1);
        chk({req, " R8 busy low at done"}, busy, 0);
        chk({req, " R4 parent_a"}, parent_a, ea);
        chk({req, " R6 parent_b"}, parent_b, eb);
        chk({req, " R6 distinct"}, (parent_a != parent_b), 1);
        @(negedge clk);
        chk({req, " R8 done one cycle"}, done, 0);
        chk({req, " R8 parents held a"}, parent_a, ea);
        chk({req, " R8 parents held b"}, parent_b, eb);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] ha, hb;
        int extra;
        fill(2'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 fit_rd", fit_rd, 0);
        chk("R1 parent_a", parent_a, 0);
        chk("R1 parent_b", parent_b, 0);

        // R2 reset seed 0xACE1 drives the first pair
        lfsr_m = 16'hACE1;
        run_pair("R2 reset-seed", 0);

        // table of seeds and fitness patterns (R3 rejection, R4, R5 ties)
        for (int v = 0; v < 8; v++) begin
            fill(VEC[v][1:0]);
            load_seed(VEC[v][17:2]);
            run_pair((VEC[v][1:0] >= 2) ? "R5 vec" : "R3 R4 vec", 0);
        end

        // R2 zero seed replaced by 0x0001
        fill(2'd3);
        load_seed(16'h0000);
        run_pair("R2 zero-seed", 0);

        // R6 back-to-back pairs with tiny spread force redraws
        fill(2'd2);
        for (int k = 0; k < 4; k++) run_pair("R6 repeat", 0);

        // R9 start and seed_load while busy are ignored
        fill(2'd1);
        load_seed(16'h4C1D);
        run_pair("R9 poke", 1);
        chk("R9 busy stays low", busy, 0);
        extra = 0;
        ha = parent_a;
        hb = parent_b;
        repeat (20) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk("R9 no stray run", extra, 0);
        chk("R8 idle hold a", parent_a, ha);
        chk("R8 idle hold b", parent_b, hb);
        // generator state after the poked run must match the unpoked model
        run_pair("R9 after poke", 0);

        chk("R7 read range", range_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule